// File: doc/BRIEF.md
# Load Data Alignment and Extension Unit

This unit sits between a 32-bit word-wide memory read port and a register-file write port. A load request carries a byte address, an access size and a signed flag. The unit sends the word-aligned address to memory in the same cycle and takes the returned word one cycle later. It then picks out the requested lanes under little-endian byte order. Narrow values are zero- or sign-extended to 32 bits, and the result is registered with a valid strobe.

Word loads from an address that is not a multiple of four keep the legacy behaviour. The aligned word is fetched and rotated right by eight bits times the byte offset. The unit neither faults nor splits the access. Halfword loads from an odd address use the enclosing aligned halfword with its two bytes swapped, so the result is always defined. A misaligned halfword or word request raises a flag beside the data, and the data is still delivered. A request may be issued every cycle, and each result appears two clock edges after its request is sampled.

Top module: `load_align_unit`

## Requirements
- R1: In the same cycle as a request, `mem_rd_en` equals `req_valid` and `mem_addr` equals `req_addr` with bits 1:0 forced to zero.
- R2: `rsp_valid` rises after the second rising edge following a sampled request and is low otherwise. Synchronous reset clears `rsp_valid`, `rsp_data` and `rsp_misaligned` to zero.
- R3: Size code 2'b00 (byte) returns the byte at the request address in bits 7:0. Memory lane k (bits 8k+7:8k) holds the byte at aligned address + k. When the signed flag is low, bits 31:8 are zero.
- R4: Size code 2'b01 (halfword) at an even address returns the byte at the address in bits 7:0 and the byte at address+1 in bits 15:8. When the signed flag is low, bits 31:16 are zero.
- R5: With `req_signed` high, a byte or halfword result copies its bit 7 or bit 15 into all higher bits. For example, byte 0x85 gives 0xFFFFFF85.
- R6: Size code 2'b10 (word) at an address that is a multiple of four returns the aligned word unchanged.
- R7: A word load at byte offset o = addr[1:0] ≠ 0 returns the aligned word rotated right by 8·o bits. Result byte j is the byte at aligned address + ((o+j) mod 4).
- R8: A halfword load at an odd address A returns the byte at A−1 in bits 15:8 and the byte at A in bits 7:0. Extension then follows R4/R5 on that 16-bit value.
- R9: `rsp_misaligned` is high with the result of a halfword at an odd address, or of a word at an address whose bits 1:0 are not zero. It is low for byte loads and aligned accesses.
- R10: Size code 2'b11 behaves exactly like a word load, including R7 and R9. `req_signed` has no effect on word or size-3 results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present this cycle |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 word |
| req_signed | input | 1 | Sign-extend narrow results |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_rdata | input | 32 | Memory word, valid the cycle after `mem_rd_en` |
| rsp_valid | output | 1 | Result valid strobe |
| rsp_data | output | 32 | Aligned and extended load value |
| rsp_misaligned | output | 1 | Request was a misaligned halfword or word |

## Verification
The assertions assume that the memory presents `mem_rdata` exactly one cycle after each read strobe. They also assume that `req_size` and `req_signed` are known whenever `req_valid` is high. The bench models memory as a synchronous array that registers its read on the strobe edge. It drives the request fields only at falling edges, with defined values even in idle cycles. The stimulus sweeps every byte offset over every size code and both sign settings. Back-to-back requests are mixed with idle gaps, so the pipeline registers see both continuous and sparse traffic.

// File: rtl/lau_pkg.sv
package lau_pkg;

  localparam int unsigned LAU_DATA_W = 32;
  localparam int unsigned LAU_LANES  = LAU_DATA_W / 8;
  localparam int unsigned LAU_OFF_W  = $clog2(LAU_LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } lau_size_e;

  typedef struct packed {
    logic                 valid;
    lau_size_e            size;
    logic                 sext;
    logic [LAU_OFF_W-1:0] off;
    logic                 misal;
  } lau_ctrl_t;

endpackage

// File: rtl/lau_req_stage.sv
module lau_req_stage
  import lau_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output lau_ctrl_t         stg_o
);

  lau_size_e            sz;
  logic [LAU_OFF_W-1:0] off;
  logic                 misal;

  assign sz  = lau_size_e'(req_size);
  assign off = req_addr[LAU_OFF_W-1:0];

  always_comb begin
    unique case (sz)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = off[0];
      default: misal = |off;
    endcase
  end

  assign mem_rd_en = req_valid;
  assign mem_addr  = {req_addr[ADDR_W-1:LAU_OFF_W], {LAU_OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_o <= '0;
    end else begin
      stg_o.valid <= req_valid;
      stg_o.size  <= sz;
      stg_o.sext  <= req_signed;
      stg_o.off   <= off;
      stg_o.misal <= req_valid & misal;
    end
  end

  // R9: flag outcome of a misaligned word request
  a_r9_word_flag: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b10 && req_addr[1:0] != 2'b00) |=> stg_o.misal);

  // R9: byte requests never flagged
  a_r9_byte_clear: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b00) |=> !stg_o.misal);

endmodule

// File: rtl/lau_lane_align.sv
module lau_lane_align
  import lau_pkg::*;
(
  input  logic [LAU_DATA_W-1:0] word_i,
  input  logic [LAU_OFF_W-1:0]  off_i,
  output logic [LAU_DATA_W-1:0] rot_o,
  output logic [15:0]           half_o
);

  logic [2*LAU_DATA_W-1:0] dbl;
  logic [15:0]             half_base;

  assign dbl   = {word_i, word_i} >> (8 * off_i);
  assign rot_o = dbl[LAU_DATA_W-1:0];

  assign half_base = off_i[1] ? word_i[31:16] : word_i[15:0];
  assign half_o    = off_i[0] ? {half_base[7:0], half_base[15:8]} : half_base;

endmodule

// File: rtl/lau_extend.sv
module lau_extend
  import lau_pkg::*;
(
  input  lau_size_e             size_i,
  input  logic                  sext_i,
  input  logic [LAU_DATA_W-1:0] rot_i,
  input  logic [15:0]           half_i,
  output logic [LAU_DATA_W-1:0] data_o
);

  logic bfill;
  logic hfill;

  assign bfill = sext_i & rot_i[7];
  assign hfill = sext_i & half_i[15];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(LAU_DATA_W-8){bfill}}, rot_i[7:0]};
      SZ_HALF: data_o = {{(LAU_DATA_W-16){hfill}}, half_i};
      default: data_o = rot_i;
    endcase
  end

endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
  import lau_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_misaligned
);

  lau_ctrl_t             stg;
  logic [LAU_DATA_W-1:0] rot;
  logic [15:0]           half;
  logic [LAU_DATA_W-1:0] shaped;

  lau_req_stage #(.ADDR_W(ADDR_W)) u_req (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_signed (req_signed),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .stg_o      (stg)
  );

  lau_lane_align u_align (
    .word_i (mem_rdata),
    .off_i  (stg.off),
    .rot_o  (rot),
    .half_o (half)
  );

  lau_extend u_ext (
    .size_i (stg.size),
    .sext_i (stg.sext),
    .rot_i  (rot),
    .half_i (half),
    .data_o (shaped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_data       <= '0;
      rsp_misaligned <= 1'b0;
    end else begin
      rsp_valid      <= stg.valid;
      rsp_data       <= stg.valid ? shaped : '0;
      rsp_misaligned <= stg.valid & stg.misal;
    end
  end

  // R2: strobe follows the data stage
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    stg.valid |=> rsp_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !stg.valid |=> !rsp_valid);

  // R3: unsigned byte upper bits cleared
  a_r3_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (stg.valid && stg.size == SZ_BYTE && !stg.sext) |=> (rsp_data[31:8] == 24'h0));

  // R4: unsigned halfword upper bits cleared
  a_r4_half_zero: assert property (@(posedge clk) disable iff (rst)
    (stg.valid && stg.size == SZ_HALF && !stg.sext) |=> (rsp_data[31:16] == 16'h0));

  // R5: signed byte replicates bit 7
  a_r5_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (stg.valid && stg.size == SZ_BYTE && stg.sext) |=> (rsp_data[31:8] == {24{rsp_data[7]}}));

endmodule

// File: tb/test_load_align_unit.sv
module test_load_align_unit;

  localparam int ADDR_W = 32;
  localparam int WORDS  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = 2'b00;
  logic              req_signed = 1'b0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_rdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_data;
  logic              rsp_misaligned;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] mem [WORDS];

  typedef struct {
    bit          v;
    logic [31:0] d;
    bit          m;
    int          sz;
    int          a;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  load_align_unit #(.ADDR_W(ADDR_W)) i_load_align_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_signed(req_signed), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_misaligned(rsp_misaligned)
  );

  always_ff @(posedge clk)
    if (mem_rd_en) mem_rdata <= mem[mem_addr[4:2]];

  function automatic logic [7:0] mbyte(int a);
    logic [31:0] w;
    w = mem[(a >> 2) % WORDS];
    return w[8*(a%4) +: 8];
  endfunction

  function automatic string tag_of(int sz, int a, bit s);
    if (sz == 0) return s ? "R5/R3" : "R3";
    if (sz == 1) begin
      if (a % 2 == 1) return "R8/R9";
      return s ? "R5/R4" : "R4";
    end
    if (sz == 3) return "R10";
    if (a % 4 != 0) return "R7/R9";
    return s ? "R10/R6" : "R6";
  endfunction

  function automatic exp_t model(bit v, int a, int sz, bit s);
    exp_t e;
    logic [7:0] lo, hi;
    int base;
    e.v = v; e.sz = sz; e.a = a; e.d = '0; e.m = 0;
    if (!v) return e;
    if (sz == 0) begin
      lo = mbyte(a);
      e.d = {24'h0, lo};
      if (s && lo[7]) e.d[31:8] = 24'hFFFFFF;
    end else if (sz == 1) begin
      if (a % 2 == 1) begin hi = mbyte(a - 1); lo = mbyte(a); e.m = 1; end
      else begin lo = mbyte(a); hi = mbyte(a + 1); end
      e.d = {16'h0, hi, lo};
      if (s && hi[7]) e.d[31:16] = 16'hFFFF;
    end else begin
      base = a - (a % 4);
      for (int j = 0; j < 4; j++) e.d[8*j +: 8] = mbyte(base + ((a % 4 + j) % 4));
      e.m = (a % 4) != 0;
    end
    return e;
  endfunction

  task automatic compare_front();
    exp_t e;
    string t;
    e = q.pop_front();
    t = e.v ? tag_of(e.sz, e.a, 0) : "R2";
    total++;
    if (rsp_valid !== e.v || (e.v && (rsp_data !== e.d || rsp_misaligned !== e.m))) begin
      bad++;
      $display("FAIL %s addr=%0d size=%0d: got v=%0b d=%h m=%0b exp v=%0b d=%h m=%0b",
               t, e.a, e.sz, rsp_valid, rsp_data, rsp_misaligned, e.v, e.d, e.m);
    end
  endtask

  task automatic step(bit v, int a, int sz, bit s);
    @(negedge clk);
    if (q.size() >= 2) compare_front();
    req_valid = v; req_addr = ADDR_W'(a); req_size = 2'(sz); req_signed = s;
    #1;
    if (v) begin
      total++;  // R1
      if (mem_rd_en !== 1'b1 || mem_addr !== (ADDR_W'(a) & ~ADDR_W'(3))) begin
        bad++;
        $display("FAIL R1 addr=%0d: got en=%0b ma=%h exp en=1 ma=%h",
                 a, mem_rd_en, mem_addr, ADDR_W'(a) & ~ADDR_W'(3));
      end
    end
    q.push_back(model(v, a, sz, s));
  endtask

  initial begin
    for (int w = 0; w < WORDS; w++)
      for (int b = 0; b < 4; b++)
        mem[w][8*b +: 8] = 8'(((w * 4 + b) * 47 + 19) % 256);
    mem[1] = 32'hEB85_0432;  // byte 6 is 0x85, halfword at 6 is 0xEB85

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    total++;  // R2 reset state
    if (rsp_valid !== 0 || rsp_data !== 0 || rsp_misaligned !== 0) begin
      bad++;
      $display("FAIL R2 reset: got v=%0b d=%h m=%0b exp 0 0 0", rsp_valid, rsp_data, rsp_misaligned);
    end
    q.push_back(model(0, 0, 0, 0));
    q.push_back(model(0, 0, 0, 0));

    // directed R5: byte 0x85 and halfword 0xEB85 signed
    step(1, 6, 0, 1);
    step(1, 6, 1, 1);
    step(1, 6, 0, 0);
    step(0, 0, 0, 0);

    // sweep of offsets, sizes and sign settings
    for (int a = 0; a < 4 * WORDS; a++)
      for (int sz = 0; sz < 4; sz++)
        for (int s = 0; s < 2; s++) begin
          step(1, a, sz, s[0]);
          if ((a + sz + s) % 5 == 0) step(0, a, sz, s[0]);
        end

    repeat (4) step(0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule